// File: doc/BRIEF.md
# Reset Sequencer with Vector Fetch

This block produces the internal reset of a small 8-bit processor core. It accepts two reset sources. The first is an external active-low pin, which passes through a synchronizer and a minimum-width filter. The second is a request from the watchdog. While any source is active the block holds the core in reset. During that time it presents the reset values of the core and peripheral control bits on dedicated outputs.

Once the sources release, the block waits a stabilization interval. A prescaler divides the clock, and a tick counter counts its output; the interval is PRESCALE × TICKS clocks, 262144 with the defaults. After the wait, a fixed seven-cycle start-up sequence runs. It has five idle bus cycles, a read of the vector low byte, then a read of the vector high byte. The program counter is then loaded and the first opcode fetch is signalled. A new request in any phase restarts the whole sequence. The block never writes memory, so RAM contents survive a reset.

Top module: `rstseq_top`

## Requirements
- R1: An external reset is accepted only after the pin has been sampled low on MIN_LOW consecutive clocks (default 8). Counting the two-flop synchronizer, core_reset rises MIN_LOW+3 clocks after the first clock edge that samples the pin low.
- R2: A low pulse on the pin that is shorter than MIN_LOW clocks has no effect: core_reset stays low and no pc_load occurs.
- R3: A watchdog request sampled at a clock edge drives core_reset high in the cycle that follows that edge.
- R4: After the last request cycle, the block stays in the stabilization wait for exactly PRESCALE×TICKS clocks. It then spends five idle cycles with bus_rd low, so the first vector read comes L+6+PRESCALE×TICKS clocks after the edge L that last sampled a request.
- R5: The vector is read in two consecutive cycles: first address VEC_ADDR (0xFFFE), then VEC_ADDR+1 (0xFFFF), each with bus_rd high.
- R6: In the cycle after the high-byte read, pc_load is high for one cycle and pc_value equals {high byte, low byte}. core_reset falls in that same cycle and stays low afterwards.
- R7: start pulses for exactly one cycle, in the same cycle as pc_load, once per completed sequence.
- R8: While core_reset is high, ctl_force is high, ctl_page is 0, and ctl_gflag, ctl_wdt_en, ctl_pclk_en and ctl_pfd_en are 0; ctl_clk_main is 1 (main clock selected). ctl_force is low while core_reset is low.
- R9: bus_wr is never asserted.
- R10: A request arriving in any phase, including the stabilization wait and the vector reads, restarts the sequence. Exactly one pc_load then follows, at the time R4 and R6 give for the last request.
- R11: While the pin stays low, core_reset stays high and the wait does not begin. With a pin low for N ≥ MIN_LOW clocks, the last request edge is N+3 clocks after the first low sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset from the analog circuit, active low |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, synchronous |
| bus_data | input | DATA_W | Read data from the byte bus |
| bus_addr | output | ADDR_W | Bus address during vector reads, zero otherwise |
| bus_rd | output | 1 | Read strobe for the vector bytes |
| bus_wr | output | 1 | Write strobe, held low |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_value | output | ADDR_W | Vector value to load |
| start | output | 1 | One-cycle strobe: first opcode fetch begins |
| core_reset | output | 1 | Core held in reset while high |
| ctl_force | output | 1 | Control reset values below are applied while high |
| ctl_page | output | PAGE_W | RAM page register reset value |
| ctl_gflag | output | 1 | G flag reset value |
| ctl_wdt_en | output | 1 | Watchdog enable reset value |
| ctl_pclk_en | output | 1 | Peripheral clock enable reset value |
| ctl_pfd_en | output | 1 | Power-fail detector enable reset value |
| ctl_clk_main | output | 1 | Operating mode selects the main clock |

## Verification
The pin filter is driven with low pulses one clock short of the threshold, exactly at the threshold, and well beyond it. This separates a filter that is off by one from a correct one, and the long pulses show that the hold tracks the pin. Watchdog pulses test the one-cycle path on their own. Second requests are placed at random points in the stabilization wait and on the vector-read cycles, which shows whether a restart clears the prescaler, the tick counter and the captured low byte. Each case uses a random vector, so a swap of the two bytes or of the read order shows up in pc_value.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [3:0] {
      S_HOLD,
      S_STAB,
      S_STEP1,
      S_STEP2,
      S_STEP3,
      S_STEP4,
      S_STEP5,
      S_FETCH_LO,
      S_FETCH_HI,
      S_RUN
   } rseq_state_e;

endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   output logic ext_hold
);
   localparam int CNT_W = $clog2(MIN_LOW + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_LOW);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rstseq_pin_filter: SYNC_STAGES must be at least 2");
      end
      if (MIN_LOW < 1) begin : g_bad_min
         $error("rstseq_pin_filter: MIN_LOW must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;
   logic [CNT_W-1:0]       low_cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
   end

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  low_cnt_q <= '0;
      else if (pin_s)              low_cnt_q <= '0;
      else if (low_cnt_q != CNT_TOP) low_cnt_q <= low_cnt_q + 1'b1;
   end

   assign ext_hold = (low_cnt_q == CNT_TOP);

   // R1: the hold can only be present after a low synchronized sample
   p_hold_after_low_r1: assert property (@(posedge clk) disable iff (!por_n)
      ext_hold |-> !$past(pin_s));

   // R2: a high sample always clears the hold on the next cycle
   p_high_clears_r2: assert property (@(posedge clk) disable iff (!por_n)
      pin_s |=> !ext_hold);

endmodule

// File: rtl/rstseq_stab_timer.sv
module rstseq_stab_timer #(
   parameter int PRESCALE = 1024,
   parameter int TICKS    = 256
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   output logic done
);
   localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam int TCK_W = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [TCK_W-1:0] TCK_LAST = TCK_W'(TICKS - 1);
   localparam longint WAIT_LEN = longint'(PRESCALE) * longint'(TICKS);

   generate
      if (PRESCALE < 1 || TICKS < 1) begin : g_bad_cfg
         $error("rstseq_stab_timer: PRESCALE and TICKS must be positive");
      end
   endgenerate

   logic             tick;
   logic [TCK_W-1:0] tck_q;

   generate
      if (PRESCALE == 1) begin : g_nopre
         assign tick = run;
      end else begin : g_pre
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)               pre_q <= '0;
            else if (!run)            pre_q <= '0;
            else if (pre_q == PRE_LAST) pre_q <= '0;
            else                      pre_q <= pre_q + 1'b1;
         end
         assign tick = run && (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      tck_q <= '0;
      else if (!run)   tck_q <= '0;
      else if (tick)   tck_q <= (tck_q == TCK_LAST) ? '0 : tck_q + 1'b1;
   end

   assign done = tick && (tck_q == TCK_LAST);

   // checker: independent count of consecutive run cycles
   logic [47:0] run_len_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    run_len_q <= '0;
      else if (!run) run_len_q <= '0;
      else           run_len_q <= run_len_q + 1'b1;
   end

   // R4: the wait ends after exactly PRESCALE*TICKS cycles of run
   p_wait_length_r4: assert property (@(posedge clk) disable iff (!por_n)
      done |-> (run_len_q == 48'(WAIT_LEN - 1)));

   p_done_needs_run_r4: assert property (@(posedge clk) disable iff (!por_n)
      !run |-> !done);

endmodule

// File: rtl/rstseq_seq.sv
module rstseq_seq
   import rstseq_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter int              DATA_W   = 8,
   parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              req,
   input  logic              stab_done,
   input  logic [DATA_W-1:0] bus_data,
   output logic              stab_run,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              start,
   output logic              core_reset
);
   localparam logic [ADDR_W-1:0] VEC_HI = VEC_ADDR + 1'b1;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("rstseq_seq: ADDR_W must be twice DATA_W");
      end
   endgenerate

   rseq_state_e       state_q, state_d;
   logic [DATA_W-1:0] lo_q;
   logic [ADDR_W-1:0] pc_q;
   logic              load_q;

   always_comb begin
      state_d = state_q;
      if (req) begin
         state_d = S_HOLD;
      end else begin
         unique case (state_q)
            S_HOLD:     state_d = S_STAB;
            S_STAB:     state_d = stab_done ? S_STEP1 : S_STAB;
            S_STEP1:    state_d = S_STEP2;
            S_STEP2:    state_d = S_STEP3;
            S_STEP3:    state_d = S_STEP4;
            S_STEP4:    state_d = S_STEP5;
            S_STEP5:    state_d = S_FETCH_LO;
            S_FETCH_LO: state_d = S_FETCH_HI;
            S_FETCH_HI: state_d = S_RUN;
            S_RUN:      state_d = S_RUN;
            default:    state_d = S_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= S_HOLD;
         lo_q    <= '0;
         pc_q    <= '0;
         load_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         load_q  <= (state_q == S_FETCH_HI) && !req;
         if (state_q == S_FETCH_LO && !req) lo_q <= bus_data;
         if (state_q == S_FETCH_HI && !req) pc_q <= {bus_data, lo_q};
      end
   end

   always_comb begin
      bus_rd   = 1'b0;
      bus_addr = '0;
      if (state_q == S_FETCH_LO) begin
         bus_rd   = 1'b1;
         bus_addr = VEC_ADDR;
      end else if (state_q == S_FETCH_HI) begin
         bus_rd   = 1'b1;
         bus_addr = VEC_HI;
      end
   end

   assign stab_run   = (state_q == S_STAB);
   assign core_reset = (state_q != S_RUN);
   assign pc_load    = load_q;
   assign pc_value   = pc_q;
   assign start      = load_q;

   // R3: any request puts the core in reset on the next cycle
   p_req_resets_r3: assert property (@(posedge clk) disable iff (!por_n)
      req |=> (core_reset && !bus_rd));

   // R5: high byte read directly follows the low byte read
   p_hi_after_lo_r5: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd && bus_addr == VEC_HI) |-> $past(bus_rd && bus_addr == VEC_ADDR));

   // R6: load follows the high byte read and coincides with release
   p_load_after_hi_r6: assert property (@(posedge clk) disable iff (!por_n)
      pc_load |-> ($past(bus_rd && bus_addr == VEC_HI) && !core_reset));

   p_release_with_load_r6: assert property (@(posedge clk) disable iff (!por_n)
      $fell(core_reset) |-> pc_load);

   // R7: start is a single-cycle strobe
   p_start_pulse_r7: assert property (@(posedge clk) disable iff (!por_n)
      start |=> !start);

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
   parameter int              ADDR_W      = 16,
   parameter int              DATA_W      = 8,
   parameter int              PAGE_W      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter int              MIN_LOW     = 8,
   parameter int              PRESCALE    = 1024,
   parameter int              TICKS       = 256,
   parameter logic [ADDR_W-1:0] VEC_ADDR  = 16'hFFFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin_n,
   input  logic              wdt_req,
   input  logic [DATA_W-1:0] bus_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              start,
   output logic              core_reset,
   output logic              ctl_force,
   output logic [PAGE_W-1:0] ctl_page,
   output logic              ctl_gflag,
   output logic              ctl_wdt_en,
   output logic              ctl_pclk_en,
   output logic              ctl_pfd_en,
   output logic              ctl_clk_main
);
   generate
      if (PAGE_W < 1) begin : g_bad_page
         $error("rstseq_top: PAGE_W must be positive");
      end
   endgenerate

   logic ext_hold;
   logic req;
   logic stab_run;
   logic stab_done;

   rstseq_pin_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_LOW     (MIN_LOW)
   ) u_filter (
      .clk      (clk),
      .por_n    (por_n),
      .pin_n    (rst_pin_n),
      .ext_hold (ext_hold)
   );

   assign req = ext_hold | wdt_req;

   rstseq_stab_timer #(
      .PRESCALE (PRESCALE),
      .TICKS    (TICKS)
   ) u_timer (
      .clk   (clk),
      .por_n (por_n),
      .run   (stab_run),
      .done  (stab_done)
   );

   rstseq_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .VEC_ADDR (VEC_ADDR)
   ) u_seq (
      .clk        (clk),
      .por_n      (por_n),
      .req        (req),
      .stab_done  (stab_done),
      .bus_data   (bus_data),
      .stab_run   (stab_run),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .pc_load    (pc_load),
      .pc_value   (pc_value),
      .start      (start),
      .core_reset (core_reset)
   );

   // memory is never written by the sequence
   assign bus_wr       = 1'b0;

   // reset values of the control bits, applied while ctl_force is high
   assign ctl_force    = core_reset;
   assign ctl_page     = '0;
   assign ctl_gflag    = 1'b0;
   assign ctl_wdt_en   = 1'b0;
   assign ctl_pclk_en  = 1'b0;
   assign ctl_pfd_en   = 1'b0;
   assign ctl_clk_main = 1'b1;

   // R8: control values are forced exactly while the core is in reset
   p_force_tracks_reset_r8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(core_reset) |-> ctl_force);

endmodule

// File: tb/rstseq_top_bench.sv
`timescale 1ns/1ps
module rstseq_top_bench;
   localparam int MINL = 8;
   localparam int PRE  = 16;
   localparam int TCK  = 4;
   localparam int PT   = PRE * TCK;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_pin_n = 1'b1;
   logic        wdt_req = 1'b0;
   logic [7:0]  bus_data;
   logic [15:0] bus_addr;
   logic        bus_rd, bus_wr, pc_load, start, core_reset;
   logic [15:0] pc_value;
   logic        ctl_force, ctl_gflag, ctl_wdt_en, ctl_pclk_en, ctl_pfd_en, ctl_clk_main;
   logic [7:0]  ctl_page;
   logic [7:0]  vlo = 8'h00, vhi = 8'h00;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   assign bus_data = (bus_addr == 16'hFFFE) ? vlo :
                     (bus_addr == 16'hFFFF) ? vhi : 8'h5A;

   rstseq_top #(
      .MIN_LOW  (MINL),
      .PRESCALE (PRE),
      .TICKS    (TCK)
   ) u_rstseq_top (
      .clk (clk), .por_n (por_n), .rst_pin_n (rst_pin_n), .wdt_req (wdt_req),
      .bus_data (bus_data), .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
      .pc_load (pc_load), .pc_value (pc_value), .start (start), .core_reset (core_reset),
      .ctl_force (ctl_force), .ctl_page (ctl_page), .ctl_gflag (ctl_gflag),
      .ctl_wdt_en (ctl_wdt_en), .ctl_pclk_en (ctl_pclk_en), .ctl_pfd_en (ctl_pfd_en),
      .ctl_clk_main (ctl_clk_main)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int last_req_edge(input int n_low, input int w1, input int w2, input int lf);
      int l = lf;
      if (n_low >= MINL && n_low + 3 > l) l = n_low + 3;
      if (w1 >= 0 && w1 + 1 > l) l = w1 + 1;
      if (w2 >= 0 && w2 + 1 > l) l = w2 + 1;
      return l;
   endfunction

   function automatic int first_rise(input int n_low, input int w1, input int lf);
      int r = 1 << 30;
      if (lf >= 0) r = 1;
      if (n_low >= MINL && MINL + 3 < r) r = MINL + 3;
      if (w1 >= 0 && w1 + 1 < r) r = w1 + 1;
      return r;
   endfunction

   // Runs one case starting at a negedge with the design in RUN (or just out of power-on).
   task automatic run_case(input int n_low, input int w1, input int w2, input int lf,
                           input string ttag);
      int l, kmax, rise_k, load_k, load_cnt, start_cnt, start_k;
      int rd_k [2];
      logic [15:0] rd_a [2];
      int rd_n;
      bit wr_seen, ctl_bad, rel_bad;
      logic [15:0] pcv;
      l = last_req_edge(n_low, w1, w2, lf);
      kmax = (l < 0) ? 40 : l + 8 + PT + 3;
      rise_k = -1; load_k = -1; load_cnt = 0; start_cnt = 0; start_k = -1;
      rd_n = 0; rd_k[0] = -1; rd_k[1] = -1; rd_a[0] = '0; rd_a[1] = '0;
      wr_seen = 0; ctl_bad = 0; rel_bad = 0; pcv = '0;
      vlo = 8'($urandom); vhi = 8'($urandom);
      if (n_low > 0) rst_pin_n = 1'b0;
      wdt_req = (w1 == 0);
      for (int k = 1; k <= kmax; k++) begin
         @(negedge clk);
         rst_pin_n = (k < n_low) ? 1'b0 : 1'b1;
         wdt_req   = (k == w1) || (k == w2);
         if (core_reset && rise_k < 0) rise_k = k;
         if (bus_rd) begin
            rd_k[0] = rd_k[1]; rd_a[0] = rd_a[1];
            rd_k[1] = k;       rd_a[1] = bus_addr;
            rd_n++;
         end
         if (pc_load) begin
            load_cnt++; load_k = k; pcv = pc_value;
            if (core_reset) rel_bad = 1;
         end
         if (start) begin start_cnt++; start_k = k; end
         if (load_k >= 0 && k > load_k && core_reset) rel_bad = 1;
         if (bus_wr) wr_seen = 1;
         if (core_reset) begin
            if (!(ctl_force && ctl_page == 8'h00 && !ctl_gflag && !ctl_wdt_en &&
                  !ctl_pclk_en && !ctl_pfd_en && ctl_clk_main)) ctl_bad = 1;
         end else if (ctl_force) ctl_bad = 1;
      end
      wdt_req = 1'b0; rst_pin_n = 1'b1;
      if (l < 0) begin
         chk(rise_k < 0, "R2 short pulse raised core_reset", rise_k, -1);
         chk(load_cnt == 0, "R2 short pulse caused pc_load", load_cnt, 0);
      end else begin
         chk(rise_k == first_rise(n_low, w1, lf),
             (n_low >= MINL) ? "R1 reset rise latency" : "R3 reset rise latency",
             rise_k, first_rise(n_low, w1, lf));
         chk(rd_k[0] == l + 6 + PT, {ttag, " first vector read cycle"}, rd_k[0], l + 6 + PT);
         chk(rd_a[0] == 16'hFFFE && rd_a[1] == 16'hFFFF && rd_k[1] == rd_k[0] + 1,
             "R5 vector read order", {rd_a[0], rd_a[1]}, {16'hFFFE, 16'hFFFF});
         chk(load_k == l + 8 + PT, {ttag, " pc_load cycle R6"}, load_k, l + 8 + PT);
         chk(pcv == {vhi, vlo}, "R6 pc_value", pcv, {vhi, vlo});
         chk(!rel_bad, "R6 core_reset release at load", rel_bad, 0);
         chk(load_cnt == 1, "R10 single pc_load", load_cnt, 1);
         chk(start_cnt == 1 && start_k == load_k, "R7 start strobe", start_k, load_k);
      end
      chk(!ctl_bad, "R8 control reset values", ctl_bad, 0);
      chk(!wr_seen, "R9 no bus write", wr_seen, 0);
   endtask

   initial begin
      int sel, n, w;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // reset state while power-on reset is asserted (R8)
      chk(core_reset === 1'b1, "R8 reset state core_reset", core_reset, 1);
      chk(bus_rd === 1'b0 && pc_load === 1'b0 && start === 1'b0, "R8 reset state strobes",
          {bus_rd, pc_load, start}, 0);
      chk(ctl_force === 1'b1 && ctl_clk_main === 1'b1 && ctl_wdt_en === 1'b0,
          "R8 reset state controls", {ctl_force, ctl_clk_main, ctl_wdt_en}, 3'b110);
      por_n = 1'b1;
      run_case(0, -1, -1, 0, "R4 power-on");
      // directed corner cases
      run_case(MINL, -1, -1, -1, "R4 pin at threshold");
      run_case(MINL - 1, -1, -1, -1, "R2");
      run_case(1, -1, -1, -1, "R2");
      run_case(MINL + 12, -1, -1, -1, "R11 held pin");
      run_case(0, 0, -1, -1, "R4 watchdog");
      run_case(0, 0, 20, -1, "R10 restart in wait");
      run_case(0, 0, PT + 7, -1, "R10 restart at low fetch");
      run_case(0, 0, PT + 8, -1, "R10 restart at high fetch");
      // random mix
      for (int t = 0; t < 10; t++) begin
         sel = $urandom % 3;
         if (sel == 0) begin
            n = MINL + ($urandom % 20);
            run_case(n, -1, -1, -1, "R11 random pin");
         end else if (sel == 1) begin
            w = $urandom % 4;
            run_case(0, w, -1, -1, "R4 random watchdog");
         end else begin
            w = 1 + ($urandom % (PT + 8));
            run_case(0, 0, w, -1, "R10 random restart");
         end
      end
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule